// File: doc/BRIEF.md
# Battery Pack Protection Fault Controller

This block is the digital decision core for a single lithium cell pack. Analog comparators outside the block turn the cell voltage and the voltage on the pack's negative terminal into clean digital flags. The block turns those flags into four controls: an enable for the charge switch gate, an enable for the discharge switch gate, a standby flag for deep discharge, and an enable for the pull-down on the pack's negative terminal.

There are five fault latches: cell overvoltage, cell undervoltage, discharge overcurrent, short circuit and charge overcurrent. Each latch has its own set condition and its own clear condition. Both conditions must hold for a parameterised number of pulses on a slow timebase strobe before the latch changes state. A two-bit test input selects normal timing, no timing at all (the latch follows its condition on the next clock), or timing in which every delay is divided by a power of two.

Top module: `bpp_fault_ctrl`

## Requirements
- R1: After a synchronous reset with `rst_n` low, `chg_en` and `dsg_en` are 1, and `standby` and `pd_en` are 0.
- R2: A set or clear condition that drops for even one clock before its qualifying count is reached is ignored. The outputs keep their state, and the count starts again from zero the next time the condition holds.
- R3: With `test_mode` = 2'b00, `cell_ov` held for OV_SET_TICKS strobes drives `chg_en` to 0 on the clock that takes the last strobe.
- R4: An overvoltage latch clears after OV_CLR_TICKS strobes with `cell_ov` = 0, `dsg_oc` = 1 and `charger_on` = 0. It never clears while `charger_on` is 1.
- R5: `cell_uv` held for UV_SET_TICKS strobes drives `dsg_en` to 0 and `standby` to 1.
- R6: The undervoltage latch clears after UV_CLR_TICKS strobes with `charger_on` = 1 and `cell_uv` = 0. It clears on the next clock if `charger_on` rises while `cell_uv` is already 0. Without a charger it does not clear.
- R7: `dsg_oc` held for ODC_SET_TICKS strobes drives `dsg_en` to 0. `pd_en` is 1 exactly while a discharge overcurrent or short circuit fault is latched.
- R8: A latched discharge overcurrent clears after ODC_CLR_TICKS strobes with `load_on` = 0 and `dsg_oc` = 0. It stays latched while `load_on` is 1.
- R9: `dsg_short` held for SC_SET_TICKS strobes drives `dsg_en` to 0. This delay is much shorter than the discharge overcurrent delay. The latch clears after SC_CLR_TICKS strobes with `load_on` = 0 and `dsg_short` = 0.
- R10: While a discharge overcurrent or short circuit fault is latched, `cell_uv` does not count and `standby` stays 0.
- R11: `chg_oc` held for OCC_SET_TICKS strobes drives `chg_en` to 0, but only while no overvoltage or undervoltage fault is latched. The latch clears after OCC_CLR_TICKS strobes with `charger_on` = 0 and `load_on` = 1.
- R12: With `test_mode` = 2'b01, every latch follows its set or clear condition on the next clock, whether or not `tick` is high.
- R13: With `test_mode[1]` = 1, every delay becomes its normal value shifted right by FAST_SHIFT, with a minimum of one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-clock timebase strobe that advances the delay counts |
| test_mode | input | 2 | 00 normal, 01 delays bypassed, 1x delays shortened |
| cell_ov | input | 1 | Cell voltage is above the overvoltage threshold |
| cell_uv | input | 1 | Cell voltage is below the undervoltage threshold |
| dsg_oc | input | 1 | Negative terminal is above the discharge overcurrent threshold (load current flows) |
| dsg_short | input | 1 | Negative terminal is above the short-circuit threshold |
| chg_oc | input | 1 | Negative terminal is below the charge overcurrent threshold |
| charger_on | input | 1 | A charger is attached |
| load_on | input | 1 | A load is attached |
| chg_en | output | 1 | Charge switch gate enable |
| dsg_en | output | 1 | Discharge switch gate enable |
| standby | output | 1 | Deep-discharge standby |
| pd_en | output | 1 | Enable for the pull-down on the negative terminal |

## Verification
Each fault's set and clear condition is swept one strobe at a time, from a single strobe up to the full qualifying count. This shows whether a latch changes exactly on its last strobe or one strobe too early or too late. The sweeps are repeated with a one-clock dropout just short of the limit, which separates a counter that restarts from one that holds its count. The blocking inputs are then applied for longer than the qualifying window: a charger during overvoltage release, a load during current-fault release, and a current fault during undervoltage. These runs show whether each clear or set term is really gated. Last, the bypass and shortened modes are tried with their own arithmetic limits, including a delay that truncates to zero and must be raised to one strobe.

// File: rtl/bpp_pkg.sv
// Package: shared types for the battery pack protection controller.
// Assumes the 2-bit test mode decode: 00 normal, 01 bypass, 1x shortened.
package bpp_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL = 2'b00,
        TM_BYPASS = 2'b01,
        TM_FAST_A = 2'b10,
        TM_FAST_B = 2'b11
    } tmode_e;

    // Delay after shortening: right shift with a floor of one strobe.
    function automatic int unsigned fast_ticks(input int unsigned base, input int unsigned shift);
        int unsigned v;
        v = base >> shift;
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/bpp_rise_det.sv
// Module: single-bit rising-edge detector.
// Assumes the input is already synchronous to clk. The output is high for
// one clock on the cycle in which the input first reads 1.
module bpp_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic sig_q;

    // Remember last cycle's value of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i && !sig_q;

endmodule

// File: rtl/bpp_qual_latch.sv
// Module: fault latch with qualified set and clear.
// The condition that would change the latch (set when clear, clear when set)
// must hold for a number of tick strobes before the latch flips. Any clock
// on which it is false resets the count. In bypass mode the latch flips on
// the next clock; in fast mode the limits are the shortened values.
// fast_clr drops a set latch at once (used for an immediate release).
// Assumes tick is a one-clock strobe and the delay parameters are >= 1.
module bpp_qual_latch
    import bpp_pkg::*;
#(
    parameter int unsigned SET_TICKS  = 8,
    parameter int unsigned CLR_TICKS  = 4,
    parameter int unsigned FAST_SHIFT = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  tmode_e mode,
    input  logic   set_cond,
    input  logic   clr_cond,
    input  logic   fast_clr,
    output logic   latched_o
);

    localparam int unsigned MAXT     = (SET_TICKS > CLR_TICKS) ? SET_TICKS : CLR_TICKS;
    localparam int unsigned CW       = $clog2(MAXT + 1);
    localparam int unsigned SET_FAST = fast_ticks(SET_TICKS, FAST_SHIFT);
    localparam int unsigned CLR_FAST = fast_ticks(CLR_TICKS, FAST_SHIFT);

    logic          latched_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic [CW:0]   cnt_nxt;
    logic          active;
    logic          bypass;

    assign bypass  = (mode == TM_BYPASS);
    assign active  = latched_q ? clr_cond : set_cond;
    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    // Pick the qualifying limit for the current direction and mode.
    always_comb begin
        if (mode[1]) lim = latched_q ? CW'(CLR_FAST) : CW'(SET_FAST);
        else         lim = latched_q ? CW'(CLR_TICKS) : CW'(SET_TICKS);
    end

    // Count strobes while the condition holds and flip at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= 1'b0;
            cnt_q     <= '0;
        end else if (latched_q && fast_clr) begin
            latched_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!active) begin
            cnt_q     <= '0;
        end else if (bypass) begin
            latched_q <= !latched_q;
            cnt_q     <= '0;
        end else if (tick) begin
            if (cnt_nxt >= {1'b0, lim}) begin
                latched_q <= !latched_q;
                cnt_q     <= '0;
            end else begin
                cnt_q     <= cnt_nxt[CW-1:0];
            end
        end
    end

    assign latched_o = latched_q;

    AST_NO_FLIP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bypass && !fast_clr) |=> $stable(latched_q)); // R12
    AST_NO_FLIP_WITHOUT_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(latched_q && fast_clr)) |=> $stable(latched_q)); // R2
    AST_COUNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/bpp_fault_ctrl.sv
// Module: battery pack protection fault controller (top).
// Five qualified fault latches decide the charge and discharge gate
// enables, deep-discharge standby and the negative-terminal pull-down.
// Assumes the comparator flags are synchronous and debounced, and that
// the current-fault set delays are shorter than the undervoltage set delay.
module bpp_fault_ctrl
    import bpp_pkg::*;
#(
    parameter int unsigned OV_SET_TICKS  = 2500,
    parameter int unsigned OV_CLR_TICKS  = 160,
    parameter int unsigned UV_SET_TICKS  = 200,
    parameter int unsigned UV_CLR_TICKS  = 12,
    parameter int unsigned ODC_SET_TICKS = 120,
    parameter int unsigned ODC_CLR_TICKS = 12,
    parameter int unsigned SC_SET_TICKS  = 4,
    parameter int unsigned SC_CLR_TICKS  = 12,
    parameter int unsigned OCC_SET_TICKS = 160,
    parameter int unsigned OCC_CLR_TICKS = 12,
    parameter int unsigned FAST_SHIFT    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] test_mode,
    input  logic       cell_ov,
    input  logic       cell_uv,
    input  logic       dsg_oc,
    input  logic       dsg_short,
    input  logic       chg_oc,
    input  logic       charger_on,
    input  logic       load_on,
    output logic       chg_en,
    output logic       dsg_en,
    output logic       standby,
    output logic       pd_en
);

    tmode_e mode;
    logic   ov_lat, uv_lat, odc_lat, sc_lat, occ_lat;
    logic   chg_rise;
    logic   cur_fault;

    assign mode      = tmode_e'(test_mode);
    assign cur_fault = odc_lat || sc_lat;

    // Detect the moment a charger is connected, for the immediate release.
    bpp_rise_det u_chg_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (charger_on),
        .rise_o (chg_rise)
    );

    // Overvoltage: release needs load current and no charger.
    bpp_qual_latch #(.SET_TICKS(OV_SET_TICKS), .CLR_TICKS(OV_CLR_TICKS), .FAST_SHIFT(FAST_SHIFT)) u_ov (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .set_cond  (cell_ov),
        .clr_cond  (!cell_ov && dsg_oc && !charger_on),
        .fast_clr  (1'b0),
        .latched_o (ov_lat)
    );

    // Undervoltage: blocked by a current fault; release needs a charger.
    bpp_qual_latch #(.SET_TICKS(UV_SET_TICKS), .CLR_TICKS(UV_CLR_TICKS), .FAST_SHIFT(FAST_SHIFT)) u_uv (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .set_cond  (cell_uv && !cur_fault),
        .clr_cond  (charger_on && !cell_uv),
        .fast_clr  (chg_rise && !cell_uv),
        .latched_o (uv_lat)
    );

    // Discharge overcurrent: release once the load is gone.
    bpp_qual_latch #(.SET_TICKS(ODC_SET_TICKS), .CLR_TICKS(ODC_CLR_TICKS), .FAST_SHIFT(FAST_SHIFT)) u_odc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .set_cond  (dsg_oc),
        .clr_cond  (!load_on && !dsg_oc),
        .fast_clr  (1'b0),
        .latched_o (odc_lat)
    );

    // Short circuit: short set delay, release once the load is gone.
    bpp_qual_latch #(.SET_TICKS(SC_SET_TICKS), .CLR_TICKS(SC_CLR_TICKS), .FAST_SHIFT(FAST_SHIFT)) u_sc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .set_cond  (dsg_short),
        .clr_cond  (!load_on && !dsg_short),
        .fast_clr  (1'b0),
        .latched_o (sc_lat)
    );

    // Charge overcurrent: armed only with both switches free of voltage faults.
    bpp_qual_latch #(.SET_TICKS(OCC_SET_TICKS), .CLR_TICKS(OCC_CLR_TICKS), .FAST_SHIFT(FAST_SHIFT)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .set_cond  (chg_oc && !ov_lat && !uv_lat),
        .clr_cond  (!charger_on && load_on),
        .fast_clr  (1'b0),
        .latched_o (occ_lat)
    );

    // Map the latched faults onto the pack controls.
    always_comb begin
        chg_en  = !(ov_lat || occ_lat);
        dsg_en  = !(uv_lat || cur_fault);
        standby = uv_lat;
        pd_en   = cur_fault;
    end

    AST_PD_ONLY_WITH_DSG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en |-> !dsg_en); // R7
    AST_STANDBY_DSG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !dsg_en); // R5
    AST_OV_HELD_WITH_CHARGER: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_lat && charger_on) |=> ov_lat); // R4
    AST_NO_STANDBY_IN_CUR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_fault && !uv_lat) |=> !uv_lat); // R10
    AST_OCC_BLOCKED_BY_UV: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lat && !occ_lat) |=> !occ_lat); // R11

endmodule

// File: tb/test_bpp_fault_ctrl.sv
// Bench: sweeps each fault's set and clear qualification on a small
// configuration and compares against limits computed here.
module test_bpp_fault_ctrl;

    localparam int unsigned P_OV_SET  = 10;
    localparam int unsigned P_OV_CLR  = 4;
    localparam int unsigned P_UV_SET  = 8;
    localparam int unsigned P_UV_CLR  = 3;
    localparam int unsigned P_ODC_SET = 6;
    localparam int unsigned P_ODC_CLR = 3;
    localparam int unsigned P_SC_SET  = 2;
    localparam int unsigned P_SC_CLR  = 3;
    localparam int unsigned P_OCC_SET = 7;
    localparam int unsigned P_OCC_CLR = 3;
    localparam int unsigned P_SHIFT   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] test_mode = 2'b00;
    logic       cell_ov = 0, cell_uv = 0, dsg_oc = 0, dsg_short = 0, chg_oc = 0;
    logic       charger_on = 0, load_on = 0;
    logic       chg_en, dsg_en, standby, pd_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bpp_fault_ctrl #(
        .OV_SET_TICKS(P_OV_SET), .OV_CLR_TICKS(P_OV_CLR),
        .UV_SET_TICKS(P_UV_SET), .UV_CLR_TICKS(P_UV_CLR),
        .ODC_SET_TICKS(P_ODC_SET), .ODC_CLR_TICKS(P_ODC_CLR),
        .SC_SET_TICKS(P_SC_SET), .SC_CLR_TICKS(P_SC_CLR),
        .OCC_SET_TICKS(P_OCC_SET), .OCC_CLR_TICKS(P_OCC_CLR),
        .FAST_SHIFT(P_SHIFT)
    ) i_bpp_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .test_mode(test_mode),
        .cell_ov(cell_ov), .cell_uv(cell_uv), .dsg_oc(dsg_oc), .dsg_short(dsg_short),
        .chg_oc(chg_oc), .charger_on(charger_on), .load_on(load_on),
        .chg_en(chg_en), .dsg_en(dsg_en), .standby(standby), .pd_en(pd_en)
    );

    function automatic int unsigned shortened(input int unsigned base);
        int unsigned v;
        v = base >> P_SHIFT;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One timebase strobe; returns at the falling edge after it was taken.
    task automatic tk();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tk();
    endtask

    task automatic clk1();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] tm);
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; test_mode = tm;
        cell_ov = 0; cell_uv = 0; dsg_oc = 0; dsg_short = 0; chg_oc = 0;
        charger_on = 0; load_on = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'b00);
        chk("R1", "chg_en", chg_en, 1'b1);
        chk("R1", "dsg_en", dsg_en, 1'b1);
        chk("R1", "standby", standby, 1'b0);
        chk("R1", "pd_en", pd_en, 1'b0);

        // R3: overvoltage set sweep
        cell_ov = 1;
        for (int k = 1; k <= int'(P_OV_SET); k++) begin
            tk();
            chk("R3", "chg_en during ov", chg_en, (k < int'(P_OV_SET)));
        end
        // R4: charger blocks release even with load current
        cell_ov = 0; dsg_oc = 1; charger_on = 1;
        ticks(P_OV_CLR);
        chk("R4", "chg_en held with charger", chg_en, 1'b0);
        dsg_oc = 0; charger_on = 0; clk1();
        dsg_oc = 1;
        for (int k = 1; k <= int'(P_OV_CLR); k++) begin
            tk();
            chk("R4", "chg_en ov release", chg_en, (k >= int'(P_OV_CLR)));
        end
        dsg_oc = 0; clk1();
        chk("R4", "no odc side effect", dsg_en, 1'b1);

        // R2: dropout restarts the count
        do_reset(2'b00);
        cell_ov = 1; ticks(P_OV_SET - 1);
        cell_ov = 0; clk1();
        cell_ov = 1; ticks(P_OV_SET - 1);
        chk("R2", "chg_en after split ov", chg_en, 1'b1);
        tk();
        chk("R2", "chg_en after full ov", chg_en, 1'b0);

        // R5: undervoltage set sweep
        do_reset(2'b00);
        cell_uv = 1;
        for (int k = 1; k <= int'(P_UV_SET); k++) begin
            tk();
            chk("R5", "dsg_en during uv", dsg_en, (k < int'(P_UV_SET)));
            chk("R5", "standby during uv", standby, (k >= int'(P_UV_SET)));
        end
        // R11: charge overcurrent blocked while undervoltage latched
        chg_oc = 1; ticks(P_OCC_SET + 1);
        chk("R11", "chg_en occ blocked by uv", chg_en, 1'b1);
        chg_oc = 0;
        // R6: no release without charger, immediate on connect
        cell_uv = 0; ticks(P_UV_CLR + 1);
        chk("R6", "standby without charger", standby, 1'b1);
        charger_on = 1; clk1();
        chk("R6", "standby immediate release", standby, 1'b0);
        chk("R6", "dsg_en immediate release", dsg_en, 1'b1);
        // R6: qualified release when cell recovers under charger
        charger_on = 0; cell_uv = 1; ticks(P_UV_SET);
        chk("R5", "standby re-entered", standby, 1'b1);
        charger_on = 1; clk1(); clk1();
        chk("R6", "no release while cell low", standby, 1'b1);
        cell_uv = 0;
        for (int k = 1; k <= int'(P_UV_CLR); k++) begin
            tk();
            chk("R6", "standby uv release", standby, (k < int'(P_UV_CLR)));
        end

        // R7: discharge overcurrent set sweep
        do_reset(2'b00);
        load_on = 1; dsg_oc = 1;
        for (int k = 1; k <= int'(P_ODC_SET); k++) begin
            tk();
            chk("R7", "dsg_en during odc", dsg_en, (k < int'(P_ODC_SET)));
            chk("R7", "pd_en during odc", pd_en, (k >= int'(P_ODC_SET)));
        end
        // R10: undervoltage ignored during current fault
        cell_uv = 1; ticks(P_UV_SET + 2);
        chk("R10", "standby during odc", standby, 1'b0);
        cell_uv = 0;
        // R8: load keeps the fault latched
        dsg_oc = 0; ticks(P_ODC_CLR + 1);
        chk("R8", "dsg_en held with load", dsg_en, 1'b0);
        load_on = 0;
        for (int k = 1; k <= int'(P_ODC_CLR); k++) begin
            tk();
            chk("R8", "dsg_en odc release", dsg_en, (k >= int'(P_ODC_CLR)));
            chk("R7", "pd_en odc release", pd_en, (k < int'(P_ODC_CLR)));
        end
        chk("R10", "standby after odc", standby, 1'b0);

        // R9: short circuit set and release
        do_reset(2'b00);
        load_on = 1; dsg_short = 1;
        for (int k = 1; k <= int'(P_SC_SET); k++) begin
            tk();
            chk("R9", "dsg_en during short", dsg_en, (k < int'(P_SC_SET)));
        end
        chk("R7", "pd_en during short", pd_en, 1'b1);
        dsg_short = 0; load_on = 0;
        for (int k = 1; k <= int'(P_SC_CLR); k++) begin
            tk();
            chk("R9", "dsg_en short release", dsg_en, (k >= int'(P_SC_CLR)));
        end

        // R11: charge overcurrent set and release
        do_reset(2'b00);
        charger_on = 1; chg_oc = 1;
        for (int k = 1; k <= int'(P_OCC_SET); k++) begin
            tk();
            chk("R11", "chg_en during occ", chg_en, (k < int'(P_OCC_SET)));
        end
        chg_oc = 0; load_on = 1; ticks(P_OCC_CLR + 1);
        chk("R11", "chg_en held with charger", chg_en, 1'b0);
        charger_on = 0;
        for (int k = 1; k <= int'(P_OCC_CLR); k++) begin
            tk();
            chk("R11", "chg_en occ release", chg_en, (k >= int'(P_OCC_CLR)));
        end

        // R12: bypass mode follows conditions without strobes
        do_reset(2'b01);
        cell_ov = 1; clk1();
        chk("R12", "chg_en bypass ov", chg_en, 1'b0);
        cell_ov = 0; cell_uv = 1; clk1();
        chk("R12", "standby bypass uv", standby, 1'b1);
        chk("R12", "dsg_en bypass uv", dsg_en, 1'b0);
        cell_uv = 0; charger_on = 1; clk1();
        chk("R12", "standby bypass release", standby, 1'b0);

        // R13: shortened delays, including the floor of one strobe
        do_reset(2'b10);
        cell_ov = 1;
        for (int k = 1; k <= int'(shortened(P_OV_SET)); k++) begin
            tk();
            chk("R13", "chg_en fast ov", chg_en, (k < int'(shortened(P_OV_SET))));
        end
        do_reset(2'b11);
        load_on = 1; dsg_short = 1;
        for (int k = 1; k <= int'(shortened(P_SC_SET)); k++) begin
            tk();
            chk("R13", "dsg_en fast short", dsg_en, (k < int'(shortened(P_SC_SET))));
        end
        clk1();
        chk("R13", "dsg_en fast short held", dsg_en, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule